// File: doc/BRIEF.md
# Exhaustive Adder Sweep Checker

This block runs a 2^(2·W) operand sweep that compares a parallel-prefix adder built on pseudo-carries with a plain reference adder. A free-running operand counter supplies both operands each cycle. The upper half of the counter is one addend and the lower half is the other. The two (W+1)-bit results, sum plus carry, are compared bit for bit. The counter advances only while three conditions hold together: the start input is high, the results agree, and the counter has not yet wrapped. The enable is a synchronous count-enable; the clock is not gated.

A mismatch sets a sticky error flag. The counter then stays on the failing operand pair, so the count output names the vector that failed. A wrap from all-ones back to zero sets a sticky done flag and ends the sweep. For test purposes, a parameter can flip one bit of the prefix adder's result at one chosen operand pair.

Top module: `adder_sweep_checker`

## Requirements
- R1: While rst_ni is low, the count, done and error outputs are all 0, asynchronously.
- R2: On each rising clock edge with counting enabled, the count goes up by one. The step after 0xFFFF gives 0.
- R3: The operand mapping is fixed. Addend A is count bits [15:8] and addend B is count bits [7:0]. A fault placed on pair {A,B} is therefore detected with count_o equal to {A,B}.
- R4: While start_i is 0, the count holds and neither flag changes.
- R5: The prefix adder returns A+B as a 9-bit value, with the carry in bit 8. With no fault configured, the sweep ends in done after exactly 65 536 enabled edges, with error still 0.
- R6: If the two results differ while start_i is 1, error_o rises on the next edge. From then on the count stays on the failing pair.
- R7: The enabled step from 0xFFFF sets done_o and leaves the count at 0. No further counting happens.
- R8: Both flags stay set until reset and are never 1 together. A mismatch at pair 0xFFFF yields error, not done.
- R9: With FLT_EN=1, bit FLT_BIT of the prefix adder's result is inverted only when the count equals FLT_PAIR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run (1) or hold (0) |
| count_o | output | 16 | Current operand pair {A,B} |
| done_o | output | 1 | Sweep completed with no mismatch |
| error_o | output | 1 | Mismatch seen; count_o holds the failing pair |

## Verification
The ending that is easiest to get wrong is a mismatch on the very last pair. There, the wrap that would set done and the miscompare that sets error compete in the same edge. An instance with a fault at 0xFFFF provokes this case. The bench expects error with count frozen at 0xFFFF and done held at 0. A second race is start_i falling while the counter sits on a faulty pair. Random start gaps from a fixed seed make this happen, and a per-cycle model expects no error until start_i is high again.

// File: rtl/adder_sweep_pkg.sv
package adder_sweep_pkg;
  localparam int unsigned OPW_DEF = 8;

  function automatic int unsigned cnt_w(int unsigned opw);
    return 2 * opw;
  endfunction
endpackage

// File: rtl/sweep_counter.sv
module sweep_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  output logic [CW-1:0] count_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;
  logic          wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (en_i) begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) wrap_q <= 1'b1;
    end
  end

  assign count_o = cnt_q;
  assign wrap_o  = wrap_q;

  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  assert_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_wrap_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wrap_q) |-> cnt_q == '0);
endmodule

// File: rtl/ref_adder.sv
module ref_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W:0]   res_o
);
  assign res_o = {1'b0, a_i} + {1'b0, b_i};
endmodule

// File: rtl/ling_prefix_adder.sv
// Prefix tree over pseudo-carries k_i = g_i | p_{i-1} & k_{i-1}; c_i = p_i & k_i.
module ling_prefix_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W:0]   res_o
);
  localparam int unsigned LV = $clog2(W);

  logic [W-1:0] g, p, h, k, kp, pprev, s;

  assign g     = a_i & b_i;
  assign p     = a_i | b_i;
  assign h     = ~g & p;
  assign pprev = {p[W-2:0], 1'b0};

  for (genvar l = 0; l < LV; l++) begin : g_lvl
    localparam int unsigned D = 1 << l;
    logic [W-1:0] gi, pi, go, po;
    if (l == 0) begin : g_first
      assign gi = g;
      assign pi = pprev;
    end else begin : g_next
      assign gi = g_lvl[l-1].go;
      assign pi = g_lvl[l-1].po;
    end
    // spans reaching bit 0 already carry P=0, so zero shift-in is exact
    assign go = gi | (pi & (gi << D));
    assign po = pi & (pi << D);
  end

  assign k  = g_lvl[LV-1].go;
  assign kp = {k[W-2:0], 1'b0};

  always_comb begin
    for (int i = 0; i < W; i++) s[i] = kp[i] ? (h[i] ^ pprev[i]) : h[i];
  end

  assign res_o = {k[W-1] & p[W-1], s};
endmodule

// File: rtl/adder_sweep_checker.sv
module adder_sweep_checker
  import adder_sweep_pkg::*;
#(
  parameter int unsigned OPW     = OPW_DEF,
  parameter bit          FLT_EN  = 1'b0,
  parameter int unsigned FLT_PAIR = 0,
  parameter int unsigned FLT_BIT = 0
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  output logic [2*OPW-1:0]      count_o,
  output logic                  done_o,
  output logic                  error_o
);
  localparam int unsigned CW = cnt_w(OPW);

  logic [CW-1:0] cnt;
  logic          wrap, en, match, error_q;
  logic [OPW-1:0] op_a, op_b;
  logic [OPW:0]  dut_raw, dut_res, ref_res;

  assign op_a = cnt[CW-1:OPW];
  assign op_b = cnt[OPW-1:0];

  ling_prefix_adder #(.W(OPW)) u_dut (.a_i(op_a), .b_i(op_b), .res_o(dut_raw));
  ref_adder         #(.W(OPW)) u_ref (.a_i(op_a), .b_i(op_b), .res_o(ref_res));

  if (FLT_EN) begin : g_flt
    localparam logic [CW-1:0] KEY = CW'(FLT_PAIR);
    always_comb begin
      dut_res = dut_raw;
      if (cnt == KEY) dut_res[FLT_BIT] = ~dut_raw[FLT_BIT];
    end
  end else begin : g_noflt
    assign dut_res = dut_raw;
  end

  assign match = (dut_res == ref_res);
  assign en    = start_i & match & ~wrap;

  sweep_counter #(.CW(CW)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en), .count_o(cnt), .wrap_o(wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         error_q <= 1'b0;
    else if (start_i && !match && !wrap) error_q <= 1'b1;
  end

  assign count_o = cnt;
  assign done_o  = wrap;
  assign error_o = error_q;

  assert_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && error_o));
  assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> error_o);
  assert_done_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
  assert_err_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> $stable(count_o));
  assert_err_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> $stable(count_o));
  assert_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(count_o) && $stable(error_o) && $stable(done_o));
  assert_flt_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!FLT_EN) |-> match);
endmodule

// File: tb/adder_sweep_checker_test.sv
module adder_sweep_checker_test;
  localparam int NI = 3;
  localparam logic [15:0] KEY1 = 16'h3CA5;
  localparam logic [15:0] KEY2 = 16'hFFFF;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  logic [15:0] cnt_w [NI];
  logic        done_w [NI];
  logic        err_w [NI];

  always #4 clk = ~clk;

  adder_sweep_checker uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .count_o(cnt_w[0]), .done_o(done_w[0]), .error_o(err_w[0]));
  adder_sweep_checker #(.FLT_EN(1'b1), .FLT_PAIR(32'h3CA5), .FLT_BIT(3)) uut_mid (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .count_o(cnt_w[1]), .done_o(done_w[1]), .error_o(err_w[1]));
  adder_sweep_checker #(.FLT_EN(1'b1), .FLT_PAIR(32'hFFFF), .FLT_BIT(8)) uut_last (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .count_o(cnt_w[2]), .done_o(done_w[2]), .error_o(err_w[2]));

  int n_chk = 0, n_fail = 0;
  logic [15:0] mc [NI];
  logic        md [NI];
  logic        me [NI];
  int          en_edges;

  function automatic bit flt_hit(int i, logic [15:0] c);
    return (i == 1 && c == KEY1) || (i == 2 && c == KEY2);
  endfunction

  task automatic chk(input string req, input int i, input logic [15:0] ec,
                     input logic ed, input logic ee);
    n_chk++;
    if (cnt_w[i] !== ec || done_w[i] !== ed || err_w[i] !== ee) begin
      n_fail++;
      $display("FAIL %s inst%0d: count=%h done=%b err=%b exp count=%h done=%b err=%b",
               req, i, cnt_w[i], done_w[i], err_w[i], ec, ed, ee);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NI; i++) begin mc[i] = '0; md[i] = 1'b0; me[i] = 1'b0; end
    en_edges = 0;
  endtask

  // drive start for the coming edge and advance the model across it
  task automatic step(input logic s);
    start = s;
    for (int i = 0; i < NI; i++) begin
      if (s && !md[i] && !me[i]) begin
        if (flt_hit(i, mc[i])) me[i] = 1'b1;   // R6, R8: error wins at 0xFFFF
        else begin
          if (mc[i] == 16'hFFFF) md[i] = 1'b1; // R7
          mc[i] = mc[i] + 1'b1;
          if (i == 0) en_edges++;
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < NI; i++) chk(req, i, mc[i], md[i], me[i]);
  endtask

  initial begin
    int cyc;
    bit fin;
    void'($urandom(32'd1234));
    model_reset();
    #1;
    check_all("R1");
    repeat (2) @(negedge clk);
    check_all("R1");
    rst_ni = 1'b1;
    // R4: hold with start low
    for (int j = 0; j < 5; j++) begin step(1'b0); check_all("R4"); end
    // R2/R3: short directed run
    for (int j = 0; j < 3; j++) begin step(1'b1); check_all("R2"); end
    step(1'b0); check_all("R4");

    cyc = 0;
    fin = 1'b0;
    while (!fin && cyc < 150000) begin
      step(($urandom % 8) != 0);
      check_all("R2");
      fin = md[0] && me[1] && me[2];
      cyc++;
    end
    if (!fin) begin
      n_fail++;
      $display("FAIL watchdog: sweep did not finish");
    end

    n_chk++;
    if (en_edges != 65536) begin
      n_fail++;
      $display("FAIL R5: enabled edges=%0d exp=65536", en_edges);
    end
    chk("R5", 0, 16'h0000, 1'b1, 1'b0);
    chk("R3", 1, KEY1, 1'b0, 1'b1);
    chk("R8", 2, KEY2, 1'b0, 1'b1);

    // R6/R8: stays frozen and sticky
    for (int j = 0; j < 4; j++) begin step(1'b1); check_all("R8"); end
    chk("R6", 1, KEY1, 1'b0, 1'b1);
    chk("R7", 0, 16'h0000, 1'b1, 1'b0);

    // R1: asynchronous reset mid-cycle
    #2 rst_ni = 1'b0;
    model_reset();
    #1 check_all("R1");
    @(negedge clk);
    rst_ni = 1'b1;
    check_all("R1");
    step(1'b1); check_all("R2");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule